// File: doc/BRIEF.md
# Dual-CAS DRAM Cycle Decoder

This block is the control front end of a 16-bit dynamic memory with two column strobes, one per byte lane. It samples the active-low row strobe, the lower and upper column strobes, the write enable and the output enable on a fast system clock, and decides what kind of memory cycle the host is running. Possible outcomes are a read, an early write, a late write, a read-modify-write, a row-only refresh, a column-before-row refresh and a hidden refresh.

From that decision it latches the row and column addresses. It merges the two column strobes into one internal strobe that asserts on the first falling lane and releases on the last rising lane. Per byte lane, it produces a tristate enable for read data and a write strobe for the array. It also keeps a 10-bit refresh row counter that steps once at the end of every self-addressed refresh. The array and all analog timing sit outside the block.

Every output is registered. An input change that is set up before rising edge k is seen on the outputs right after rising edge k+1.

Top module: `dcas_cycle_decoder`

## Requirements
- R1: After reset the cycle type is idle (code 0), and the lane enables, write strobes, merged strobe, latched addresses and refresh row are all zero.
- R2: The merged strobe `cas_o` goes to 1 when either column strobe goes low. It returns to 0 only when both column strobes are high.
- R3: Row strobe low while both column strobes are high gives cycle code 5. The row is taken from the address at the row strobe fall. No lane is enabled and no lane is written.
- R4: A column strobe fall with write enable high gives cycle code 3'd1 (read) and latches the column once per strobe phase. Lane bit 0 follows the lower strobe (data bits 7:0) and lane bit 1 follows the upper strobe (bits 15:8). A lane is enabled only while its own strobe is low.
- R5: During a read, lane enables are on only while output enable is low. Data therefore starts at the later of the column fall and the output-enable fall, and stops when output enable rises first.
- R6: Write enable low at the column fall gives cycle code 2 (early write). Write strobes follow the low lanes. Lane enables stay off for the whole cycle, even with output enable low.
- R7: Write enable falling during a read in which no lane has yet been enabled gives cycle code 3 (late write), with write strobes on the low lanes.
- R8: Write enable falling during a read in which a lane has already been enabled gives cycle code 4 (read-modify-write). Write strobes turn on, and a lane is never enabled and written in the same cycle.
- R9: A column strobe low before the row strobe falls gives cycle code 6. The address is ignored, so the row output keeps its value. Lane enables and write strobes stay off whatever output enable does.
- R10: The refresh row steps by exactly one, modulo 1024, when the row strobe rises to end a code-6 or code-7 cycle, and at no other time.
- R11: Raising and lowering the row strobe while the column strobes stay low after a read gives cycle code 7. The lane enables keep driving the held read data through the whole sequence.
- R12: With the row strobe held low, raising and lowering the column strobes starts a new access in the same row. It latches the new column and classifies the new access from the write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| lcas_ni | input | 1 | Lower-lane column strobe, active low |
| ucas_ni | input | 1 | Upper-lane column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Multiplexed row/column address |
| cycle_o | output | 3 | Cycle type code |
| row_o | output | ADDR_W | Latched row address |
| col_o | output | ADDR_W | Latched column address |
| wr_lane_o | output | 2 | Per-lane write strobes (bit 0 lower) |
| oe_lane_o | output | 2 | Per-lane tristate enables (bit 0 lower) |
| cas_o | output | 1 | Merged internal column strobe |
| rfsh_row_o | output | ADDR_W | Refresh row counter |

## Verification
Each result lands two rising edges after the strobe change that causes it: one edge for the input sampler, and one for the state and output registers. This holds for the cycle code, the addresses, the lane vectors, the merged strobe and the refresh count alike. The driver records the cycle count at which it changes the strobes and queues each expected value with a due cycle two higher. The monitor compares the outputs on the falling edge of that cycle. Each stimulus step moves a single strobe group and then waits three cycles, so every expectation describes one settled state transition.

// File: rtl/dcas_pkg.sv
package dcas_pkg;
  localparam int NUM_LANES = 2;

  typedef enum logic [2:0] {
    CYC_IDLE     = 3'd0,
    CYC_READ     = 3'd1,
    CYC_EARLY_WR = 3'd2,
    CYC_LATE_WR  = 3'd3,
    CYC_RMW      = 3'd4,
    CYC_RAS_ONLY = 3'd5,
    CYC_CBR      = 3'd6,
    CYC_HIDDEN   = 3'd7
  } cyc_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_ACC,
    ST_CASPRE,
    ST_REF,
    ST_HOLD
  } st_e;

  // active-high view of the sampled strobes
  typedef struct packed {
    logic                 ras;
    logic                 we;
    logic                 oe;
    logic [NUM_LANES-1:0] cas;
  } strb_t;
endpackage

// File: rtl/dcas_strobe_sampler.sv
module dcas_strobe_sampler
  import dcas_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ras_ni,
  input  logic [NUM_LANES-1:0] cas_ni,
  input  logic                 we_ni,
  input  logic                 oe_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  output strb_t                strb_o,
  output logic [ADDR_W-1:0]    addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_o <= '0;
      addr_o <= '0;
    end else begin
      strb_o.ras <= ~ras_ni;
      strb_o.we  <= ~we_ni;
      strb_o.oe  <= ~oe_ni;
      strb_o.cas <= ~cas_ni;
      addr_o     <= addr_i;
    end
  end
endmodule

// File: rtl/dcas_refresh_ctr.sv
module dcas_refresh_ctr #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/dcas_lane_ctl.sv
module dcas_lane_ctl
  import dcas_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LANES-1:0] lane_act_i,
  input  logic                 drive_ok_i,
  input  logic                 write_ok_i,
  output logic                 rd_any_o,
  output logic [NUM_LANES-1:0] rd_en_o,
  output logic [NUM_LANES-1:0] wr_en_o,
  output logic                 cas_o
);
  logic [NUM_LANES-1:0] rd_d, wr_d;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign rd_d[g] = lane_act_i[g] & drive_ok_i;
    assign wr_d[g] = lane_act_i[g] & write_ok_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rd_en_o[g] <= 1'b0;
        wr_en_o[g] <= 1'b0;
      end else begin
        rd_en_o[g] <= rd_d[g];
        wr_en_o[g] <= wr_d[g];
      end
    end
  end

  assign rd_any_o = |rd_d;

  // first lane low sets, last lane high clears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cas_o <= 1'b0;
    else         cas_o <= |lane_act_i;
  end
endmodule

// File: rtl/dcas_cycle_fsm.sv
module dcas_cycle_fsm
  import dcas_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  strb_t             strb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_any_i,
  output cyc_e              cyc_o,
  output logic [ADDR_W-1:0] row_o,
  output logic [ADDR_W-1:0] col_o,
  output logic              drive_ok_o,
  output logic              write_ok_o,
  output logic              rfsh_inc_o
);
  st_e               st_q, st_d;
  cyc_e              cyc_q, cyc_d;
  logic [ADDR_W-1:0] row_d, col_d;
  logic              hold_q, hold_d;
  logic              drove_q, drove_d;
  logic              cas;

  assign cas = |strb_i.cas;

  always_comb begin
    st_d   = st_q;
    cyc_d  = cyc_q;
    row_d  = row_o;
    col_d  = col_o;
    hold_d = hold_q;
    unique case (st_q)
      ST_IDLE: begin
        if (strb_i.ras) begin
          st_d  = ST_ROW;
          row_d = addr_i;
          cyc_d = CYC_RAS_ONLY;
        end else if (cas) begin
          st_d  = ST_CASPRE;
          cyc_d = CYC_IDLE;
        end
      end
      ST_CASPRE: begin
        if (!cas) begin
          st_d  = ST_IDLE;
          cyc_d = CYC_IDLE;
        end else if (strb_i.ras) begin
          st_d  = ST_REF;
          cyc_d = CYC_CBR;
        end
      end
      ST_ROW: begin
        if (!strb_i.ras) begin
          st_d  = ST_IDLE;
          cyc_d = CYC_IDLE;
        end else if (cas) begin
          st_d  = ST_ACC;
          col_d = addr_i;
          cyc_d = strb_i.we ? CYC_EARLY_WR : CYC_READ;
        end
      end
      ST_ACC: begin
        if (!strb_i.ras) begin
          if (cas) begin
            st_d   = ST_HOLD;
            hold_d = (cyc_q == CYC_READ) || (cyc_q == CYC_RMW);
          end else begin
            st_d  = ST_IDLE;
            cyc_d = CYC_IDLE;
          end
        end else if (!cas) begin
          st_d = ST_ROW;
        end else if (cyc_q == CYC_READ && strb_i.we) begin
          cyc_d = drove_q ? CYC_RMW : CYC_LATE_WR;
        end
      end
      ST_REF: begin
        if (!strb_i.ras) begin
          if (cas) begin
            if (cyc_q == CYC_HIDDEN) begin
              st_d = ST_HOLD;
            end else begin
              st_d  = ST_CASPRE;
              cyc_d = CYC_IDLE;
            end
          end else begin
            st_d  = ST_IDLE;
            cyc_d = CYC_IDLE;
          end
        end
      end
      ST_HOLD: begin
        if (!cas) begin
          st_d  = ST_IDLE;
          cyc_d = CYC_IDLE;
        end else if (strb_i.ras) begin
          st_d  = ST_REF;
          cyc_d = CYC_HIDDEN;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        cyc_d = CYC_IDLE;
      end
    endcase
    if (st_d == ST_IDLE) hold_d = 1'b0;
  end

  // data-driven flag separates late write from read-modify-write
  always_comb begin
    drove_d = 1'b0;
    if (st_d == ST_ACC)
      drove_d = ((st_q == ST_ACC) ? drove_q : 1'b0) | rd_any_i;
  end

  always_comb begin
    drive_ok_o = 1'b0;
    if (strb_i.oe && !strb_i.we) begin
      if (st_d == ST_ACC && (cyc_d == CYC_READ || cyc_d == CYC_RMW))
        drive_ok_o = 1'b1;
      else if ((st_d == ST_HOLD || (st_d == ST_REF && cyc_d == CYC_HIDDEN)) && hold_d)
        drive_ok_o = 1'b1;
    end
  end

  assign write_ok_o = strb_i.we && (st_d == ST_ACC) &&
                      (cyc_d == CYC_EARLY_WR || cyc_d == CYC_LATE_WR || cyc_d == CYC_RMW);

  assign rfsh_inc_o = (st_q == ST_REF) && !strb_i.ras;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cyc_q   <= CYC_IDLE;
      row_o   <= '0;
      col_o   <= '0;
      hold_q  <= 1'b0;
      drove_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cyc_q   <= cyc_d;
      row_o   <= row_d;
      col_o   <= col_d;
      hold_q  <= hold_d;
      drove_q <= drove_d;
    end
  end

  assign cyc_o = cyc_q;
endmodule

// File: rtl/dcas_cycle_decoder.sv
module dcas_cycle_decoder
  import dcas_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              lcas_ni,
  input  logic              ucas_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [2:0]        cycle_o,
  output logic [ADDR_W-1:0] row_o,
  output logic [ADDR_W-1:0] col_o,
  output logic [1:0]        wr_lane_o,
  output logic [1:0]        oe_lane_o,
  output logic              cas_o,
  output logic [ADDR_W-1:0] rfsh_row_o
);
  strb_t             strb_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_any, drive_ok, write_ok, rfsh_inc;
  cyc_e              cyc;

  dcas_strobe_sampler #(.ADDR_W(ADDR_W)) u_sampler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ras_ni (ras_ni),
    .cas_ni ({ucas_ni, lcas_ni}),
    .we_ni  (we_ni),
    .oe_ni  (oe_ni),
    .addr_i (addr_i),
    .strb_o (strb_q),
    .addr_o (addr_q)
  );

  dcas_cycle_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strb_i     (strb_q),
    .addr_i     (addr_q),
    .rd_any_i   (rd_any),
    .cyc_o      (cyc),
    .row_o      (row_o),
    .col_o      (col_o),
    .drive_ok_o (drive_ok),
    .write_ok_o (write_ok),
    .rfsh_inc_o (rfsh_inc)
  );

  dcas_lane_ctl u_lanes (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lane_act_i (strb_q.cas),
    .drive_ok_i (drive_ok),
    .write_ok_i (write_ok),
    .rd_any_o   (rd_any),
    .rd_en_o    (oe_lane_o),
    .wr_en_o    (wr_lane_o),
    .cas_o      (cas_o)
  );

  dcas_refresh_ctr #(.CNT_W(ADDR_W)) u_rfsh (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (rfsh_inc),
    .cnt_o  (rfsh_row_o)
  );

  assign cycle_o = cyc;
endmodule

// File: rtl/dcas_cycle_decoder_sva.sv
module dcas_cycle_decoder_sva
  import dcas_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ras_ni,
  input logic              lcas_ni,
  input logic              ucas_ni,
  input logic              we_ni,
  input logic              oe_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [2:0]        cycle_o,
  input logic [ADDR_W-1:0] row_o,
  input logic [ADDR_W-1:0] col_o,
  input logic [1:0]        wr_lane_o,
  input logic [1:0]        oe_lane_o,
  input logic              cas_o,
  input logic [ADDR_W-1:0] rfsh_row_o
);
  assert_cas_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_o) |-> $past({ucas_ni, lcas_ni}, 2) == 2'b11);

  assert_rasonly_nodata_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_o == CYC_RAS_ONLY |-> (oe_lane_o == 2'b00 && wr_lane_o == 2'b00));

  assert_lane_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |oe_lane_o |-> (oe_lane_o & $past({ucas_ni, lcas_ni}, 2)) == 2'b00);

  assert_early_hiz_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_o == CYC_EARLY_WR |-> oe_lane_o == 2'b00);

  assert_rw_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_lane_o & wr_lane_o) == 2'b00);

  assert_cbr_hiz_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_o == CYC_CBR |-> (oe_lane_o == 2'b00 && wr_lane_o == 2'b00));

  assert_cbr_row_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_o == CYC_CBR && $past(cycle_o) == CYC_CBR) |-> $stable(row_o));

  assert_ctr_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rfsh_row_o) |-> rfsh_row_o == ADDR_W'($past(rfsh_row_o) + 1'b1));

  assert_ctr_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rfsh_row_o) |-> ($past(cycle_o) == CYC_CBR || $past(cycle_o) == CYC_HIDDEN));
endmodule

bind dcas_cycle_decoder dcas_cycle_decoder_sva #(.ADDR_W(ADDR_W)) u_sva (.*);

// File: tb/dcas_cycle_decoder_test.sv
`timescale 1ns/1ps
module dcas_cycle_decoder_test;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ras_ni = 1'b1, lcas_ni = 1'b1, ucas_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [2:0]    cycle_o;
  logic [AW-1:0] row_o, col_o, rfsh_row_o;
  logic [1:0]    wr_lane_o, oe_lane_o;
  logic          cas_o;

  always #10 clk = ~clk;

  dcas_cycle_decoder #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .ras_ni(ras_ni), .lcas_ni(lcas_ni), .ucas_ni(ucas_ni),
    .we_ni(we_ni), .oe_ni(oe_ni), .addr_i(addr_i), .cycle_o(cycle_o), .row_o(row_o),
    .col_o(col_o), .wr_lane_o(wr_lane_o), .oe_lane_o(oe_lane_o), .cas_o(cas_o),
    .rfsh_row_o(rfsh_row_o)
  );

  localparam int K_CYC = 0, K_ROW = 1, K_COL = 2, K_WR = 3, K_OE = 4, K_RF = 5, K_CAS = 6;

  typedef struct {
    int    due;
    int    kind;
    int    val;
    string req;
  } exp_t;

  exp_t  q[$];
  exp_t  mon_e;
  int    cyc = 0;
  int    drv_cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int actual(int kind);
    case (kind)
      K_CYC:   return int'(cycle_o);
      K_ROW:   return int'(row_o);
      K_COL:   return int'(col_o);
      K_WR:    return int'(wr_lane_o);
      K_OE:    return int'(oe_lane_o);
      K_RF:    return int'(rfsh_row_o);
      default: return int'(cas_o);
    endcase
  endfunction

  function automatic string kname(int kind);
    case (kind)
      K_CYC:   return "cycle";
      K_ROW:   return "row";
      K_COL:   return "col";
      K_WR:    return "wr_lane";
      K_OE:    return "oe_lane";
      K_RF:    return "rfsh_row";
      default: return "cas";
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h @cyc %0d", req, what, act, expv, cyc);
    end
  endtask

  // monitor: compare each queued expectation in its due cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      mon_e = q.pop_front();
      chk(mon_e.req, kname(mon_e.kind), actual(mon_e.kind), mon_e.val);
    end
  end

  task automatic drv(input logic r, input logic l, input logic u, input logic w,
                     input logic o, input int a);
    ras_ni  = r;
    lcas_ni = l;
    ucas_ni = u;
    we_ni   = w;
    oe_ni   = o;
    addr_i  = AW'(a);
    drv_cyc = cyc;
  endtask

  task automatic ex(int kind, int val, string req);
    q.push_back('{drv_cyc + 2, kind, val, req});
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic cbr_quiet();
    drv(1, 0, 1, 1, 1, 0); settle();
    drv(0, 0, 1, 1, 1, 0); settle();
    drv(1, 0, 1, 1, 1, 0); settle();
    drv(1, 1, 1, 1, 1, 0); settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "cycle", int'(cycle_o), 0);
    chk("R1", "oe_lane", int'(oe_lane_o), 0);
    chk("R1", "wr_lane", int'(wr_lane_o), 0);
    chk("R1", "cas", int'(cas_o), 0);
    chk("R1", "rfsh_row", int'(rfsh_row_o), 0);
    chk("R1", "row", int'(row_o), 0);
    chk("R1", "col", int'(col_o), 0);

    // R3 row-only refresh
    drv(0, 1, 1, 1, 1, 'h155); ex(K_CYC, 5, "R3"); ex(K_ROW, 'h155, "R3");
    ex(K_OE, 0, "R3"); ex(K_WR, 0, "R3"); settle();
    drv(1, 1, 1, 1, 1, 0); ex(K_CYC, 0, "R3"); settle();

    // R4/R5 word read, output-enable control
    drv(0, 1, 1, 1, 1, 'h0A3); ex(K_ROW, 'h0A3, "R4"); settle();
    drv(0, 0, 0, 1, 1, 'h321); ex(K_CYC, 1, "R4"); ex(K_COL, 'h321, "R4");
    ex(K_OE, 0, "R5"); ex(K_CAS, 1, "R2"); settle();
    drv(0, 0, 0, 1, 0, 'h321); ex(K_OE, 3, "R5"); settle();
    drv(0, 0, 0, 1, 1, 'h321); ex(K_OE, 0, "R5"); settle();
    drv(0, 1, 1, 1, 1, 0); ex(K_CAS, 0, "R2"); ex(K_OE, 0, "R5"); settle();
    drv(1, 1, 1, 1, 1, 0); ex(K_CYC, 0, "R3"); settle();

    // R2/R4 byte lanes and strobe merge
    drv(0, 1, 1, 1, 1, 'h011); settle();
    drv(0, 0, 1, 1, 1, 'h022); ex(K_CYC, 1, "R4"); ex(K_CAS, 1, "R2"); ex(K_OE, 0, "R5"); settle();
    drv(0, 0, 1, 1, 0, 'h022); ex(K_OE, 1, "R4"); settle();
    drv(0, 0, 0, 1, 0, 'h0FF); ex(K_OE, 3, "R4"); ex(K_COL, 'h022, "R4"); ex(K_CAS, 1, "R2"); settle();
    drv(0, 1, 0, 1, 0, 'h0FF); ex(K_CAS, 1, "R2"); ex(K_OE, 2, "R4"); settle();
    drv(0, 1, 1, 1, 0, 'h0FF); ex(K_CAS, 0, "R2"); ex(K_OE, 0, "R4"); settle();
    drv(0, 1, 1, 1, 1, 0); settle();
    drv(1, 1, 1, 1, 1, 0); settle();

    // R6 early write, upper lane only, OE low
    drv(0, 1, 1, 1, 1, 'h001); settle();
    drv(0, 1, 1, 0, 0, 'h001); settle();
    drv(0, 1, 0, 0, 0, 'h2AA); ex(K_CYC, 2, "R6"); ex(K_COL, 'h2AA, "R6");
    ex(K_WR, 2, "R6"); ex(K_OE, 0, "R6"); settle();
    drv(0, 1, 1, 0, 0, 0); ex(K_WR, 0, "R6"); settle();
    drv(0, 1, 1, 1, 1, 0); settle();
    drv(1, 1, 1, 1, 1, 0); settle();

    // R7 late write
    drv(0, 1, 1, 1, 1, 'h007); settle();
    drv(0, 0, 0, 1, 1, 'h03C); ex(K_CYC, 1, "R7"); settle();
    drv(0, 0, 0, 0, 1, 'h03C); ex(K_CYC, 3, "R7"); ex(K_WR, 3, "R7"); ex(K_OE, 0, "R7"); settle();
    drv(0, 1, 1, 0, 1, 0); ex(K_WR, 0, "R7"); settle();
    drv(0, 1, 1, 1, 1, 0); settle();
    drv(1, 1, 1, 1, 1, 0); settle();

    // R8 read-modify-write, lower lane
    drv(0, 1, 1, 1, 1, 'h009); settle();
    drv(0, 0, 1, 1, 1, 'h012); settle();
    drv(0, 0, 1, 1, 0, 'h012); ex(K_OE, 1, "R8"); settle();
    drv(0, 0, 1, 1, 1, 'h012); ex(K_OE, 0, "R8"); settle();
    drv(0, 0, 1, 0, 1, 'h012); ex(K_CYC, 4, "R8"); ex(K_WR, 1, "R8"); ex(K_OE, 0, "R8"); settle();
    drv(0, 1, 1, 0, 1, 0); settle();
    drv(0, 1, 1, 1, 1, 0); settle();
    drv(1, 1, 1, 1, 1, 0); settle();

    // R12 page mode: read then early write in the same row
    drv(0, 1, 1, 1, 1, 'h100); ex(K_ROW, 'h100, "R12"); settle();
    drv(0, 0, 0, 1, 1, 'h005); ex(K_COL, 'h005, "R12"); ex(K_CYC, 1, "R12"); settle();
    drv(0, 1, 1, 1, 1, 'h005); ex(K_CAS, 0, "R12"); settle();
    drv(0, 1, 1, 0, 1, 'h006); settle();
    drv(0, 0, 0, 0, 1, 'h006); ex(K_COL, 'h006, "R12"); ex(K_CYC, 2, "R12");
    ex(K_WR, 3, "R12"); ex(K_ROW, 'h100, "R12"); settle();
    drv(0, 1, 1, 0, 1, 0); settle();
    drv(0, 1, 1, 1, 1, 0); settle();
    drv(1, 1, 1, 1, 1, 0); ex(K_CYC, 0, "R12"); settle();

    // R9/R10 column-before-row refresh
    drv(1, 0, 1, 1, 1, 0); ex(K_CYC, 0, "R9"); ex(K_CAS, 1, "R2"); settle();
    drv(0, 0, 1, 1, 1, 'h3FF); ex(K_CYC, 6, "R9"); ex(K_ROW, 'h100, "R9");
    ex(K_RF, 0, "R10"); ex(K_OE, 0, "R9"); settle();
    drv(0, 0, 1, 1, 0, 'h3FF); ex(K_OE, 0, "R9"); ex(K_WR, 0, "R9"); settle();
    drv(1, 0, 1, 1, 0, 0); ex(K_RF, 1, "R10"); ex(K_CYC, 0, "R9"); settle();
    drv(0, 0, 1, 1, 1, 'h002); ex(K_CYC, 6, "R9"); ex(K_RF, 1, "R10"); settle();
    drv(1, 0, 1, 1, 1, 0); ex(K_RF, 2, "R10"); settle();
    drv(1, 1, 1, 1, 1, 0); ex(K_CAS, 0, "R2"); ex(K_CYC, 0, "R9"); settle();

    // R11 hidden refresh after a read
    drv(0, 1, 1, 1, 1, 'h040); ex(K_ROW, 'h040, "R11"); settle();
    drv(0, 0, 0, 1, 1, 'h041); settle();
    drv(0, 0, 0, 1, 0, 'h041); ex(K_OE, 3, "R11"); settle();
    drv(1, 0, 0, 1, 0, 0); ex(K_CYC, 1, "R11"); ex(K_OE, 3, "R11"); settle();
    drv(0, 0, 0, 1, 0, 'h155); ex(K_CYC, 7, "R11"); ex(K_OE, 3, "R11");
    ex(K_RF, 2, "R11"); ex(K_ROW, 'h040, "R11"); settle();
    drv(1, 0, 0, 1, 0, 0); ex(K_RF, 3, "R11"); ex(K_OE, 3, "R11"); settle();
    drv(1, 1, 1, 1, 0, 0); ex(K_OE, 0, "R11"); ex(K_CYC, 0, "R11"); settle();
    drv(1, 1, 1, 1, 1, 0); settle();

    // R10 counter wrap at 1024
    for (int i = 0; i < 1020; i++) cbr_quiet();
    drv(1, 1, 1, 1, 1, 0); ex(K_RF, 1023, "R10"); settle();
    drv(1, 0, 1, 1, 1, 0); settle();
    drv(0, 0, 1, 1, 1, 0); ex(K_RF, 1023, "R10"); settle();
    drv(1, 0, 1, 1, 1, 0); ex(K_RF, 0, "R10"); settle();
    drv(1, 1, 1, 1, 1, 0); settle();

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule